// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Triggers

This block is a 32-pin general-purpose I/O port that a processor controls over a simple 32-bit register bus. Each pin has an output value and a direction bit. The pin is driven only when its direction bit is one; otherwise it floats. The level seen on every pin is brought in through a two-flop synchronizer and can be read back whatever the direction is.

Every pin can also raise an interrupt. A 2-bit code chosen per pin selects the trigger: low level, high level, rising edge or falling edge. A detected trigger sets a sticky status bit, and software clears that bit by writing a one to it. A mask register gates the status onto two interrupt lines, one for the lower sixteen pins and one for the upper sixteen.

Bus accesses take effect at the clock edge where `bus_en` and `bus_we` are both high. Read data is a combinational function of `bus_addr` and the register state. The byte offsets are: output value 0x00, direction 0x04, synchronized pin level 0x08, lower trigger codes 0x0C, upper trigger codes 0x10, mask 0x14, status 0x18. Any other offset reads as zero.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is asserted and just after it is released, the output value, direction, mask, status and both trigger-code registers read zero, and `pin_oe`, `pin_out`, `irq_lo` and `irq_hi` are zero.
- R2: `pin_oe[n]` equals direction bit n. `pin_out[n]` is output value bit n where direction bit n is one, and zero where it is zero. Both registers read back what was written.
- R3: Offset 0x08 returns `pin_in` delayed by two clock edges for every pin, whatever the direction. After a change, the old value is still read one cycle later.
- R4: Pin n takes its code from register 0x0C when n < 16 and from 0x10 otherwise, at bits [2k+1:2k] with k = n mod 16. A status bit is only ever set by its own pin's trigger.
- R5: Writing a one to a status bit clears it and writing a zero leaves it unchanged. A status bit, once set, stays set until it is cleared.
- R6: A pin's status reaches an interrupt output only while its mask bit is one. With the mask at zero, both outputs are low.
- R7: `irq_lo` is the OR of masked status for pins 0..15 and `irq_hi` the OR for pins 16..31. A masked pending bit in one half does not raise the other half's output.
- R8: Code 0 (low level) sets the status bit on every cycle in which the synchronized pin is low. A clear written during that time has no effect.
- R9: Code 1 (high level) sets the status bit on every cycle in which the synchronized pin is high. A clear written during that time has no effect.
- R10: Code 2 sets status once on a synchronized 0-to-1 change and code 3 once on a 1-to-0 change. A steady pin does not set it again after a clear. Status becomes visible three clock edges after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output value toward the pads |
| pin_oe | output | 32 | Output enable per pin |
| irq_lo | output | 1 | Interrupt for pins 0..15 |
| irq_hi | output | 1 | Interrupt for pins 16..31 |

## Verification
The checker watches four things on every cycle:
- status bits never drop without a write-one clear;
- no status bit rises unless its own pin's trigger fired in the cycle before;
- the two interrupt lines together agree with whether any masked status is pending, and both stay low under a zero mask;
- no pin drives a one while its output enable is off.

Other properties depend on particular input sequences, so only the bench scenarios can show them. These are:
- the placement of each trigger code's field;
- the exact two-edge latency of the pin readback and the three-edge latency of status;
- that a level trigger defeats a clear while an edge trigger does not;
- that each half's masked status goes only to its own interrupt line.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  localparam logic [7:0] OFS_OUTVAL = 8'h00;
  localparam logic [7:0] OFS_DIR    = 8'h04;
  localparam logic [7:0] OFS_LEVEL  = 8'h08;
  localparam logic [7:0] OFS_TRIGLO = 8'h0C;
  localparam logic [7:0] OFS_TRIGHI = 8'h10;
  localparam logic [7:0] OFS_MASK   = 8'h14;
  localparam logic [7:0] OFS_STAT   = 8'h18;

  // Decide whether one pin fires its trigger this cycle.
  function automatic logic trig_fires(trig_e t, logic now_lvl, logic was_lvl);
    case (t)
      TRIG_LOW:  return !now_lvl;
      TRIG_HIGH: return now_lvl;
      TRIG_RISE: return now_lvl && !was_lvl;
      default:   return !now_lvl && was_lvl;
    endcase
  endfunction

  // Field index of a pin inside its half's code register.
  function automatic int unsigned field_slot(int unsigned pin, int unsigned half);
    return pin % half;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      q_prev <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      q_prev <= stg[STAGES-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_trig.sv
`timescale 1ns/1ps
module gpio_trig import gpio_irq_pkg::*; #(
  parameter int unsigned PINS = 32
) (
  input  logic [2*(PINS/2)-1:0] cfg_lo,
  input  logic [2*(PINS/2)-1:0] cfg_hi,
  input  logic [PINS-1:0]       cur,
  input  logic [PINS-1:0]       prv,
  output logic [PINS-1:0]       hit
);
  localparam int unsigned HALF = PINS / 2;

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    localparam int unsigned K = field_slot(n, HALF);
    logic [1:0] code;
    if (n < HALF) begin : g_low
      assign code = cfg_lo[2*K +: 2];
    end else begin : g_high
      assign code = cfg_hi[2*K +: 2];
    end
    assign hit[n] = trig_fires(trig_e'(code), cur[n], prv[n]);
  end
endmodule

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs import gpio_irq_pkg::*; #(
  parameter int unsigned PINS = 32,
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_en,
  input  logic                  bus_we,
  input  logic [AW-1:0]         bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  input  logic [PINS-1:0]       level_q,
  input  logic [PINS-1:0]       hit_vec,
  output logic [DW-1:0]         bus_rdata,
  output logic [PINS-1:0]       outval_q,
  output logic [PINS-1:0]       dir_q,
  output logic [2*(PINS/2)-1:0] cfg_lo_q,
  output logic [2*(PINS/2)-1:0] cfg_hi_q,
  output logic [PINS-1:0]       mask_q,
  output logic [PINS-1:0]       stat_q,
  output logic [PINS-1:0]       clr_vec
);
  localparam int unsigned CFG_W = 2 * (PINS / 2);

  logic wr;
  logic wr_out, wr_dir, wr_tlo, wr_thi, wr_msk, wr_stat;

  assign wr      = bus_en && bus_we;
  assign wr_out  = wr && (bus_addr == AW'(OFS_OUTVAL));
  assign wr_dir  = wr && (bus_addr == AW'(OFS_DIR));
  assign wr_tlo  = wr && (bus_addr == AW'(OFS_TRIGLO));
  assign wr_thi  = wr && (bus_addr == AW'(OFS_TRIGHI));
  assign wr_msk  = wr && (bus_addr == AW'(OFS_MASK));
  assign wr_stat = wr && (bus_addr == AW'(OFS_STAT));

  assign clr_vec = wr_stat ? bus_wdata[PINS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outval_q <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      stat_q   <= '0;
    end else begin
      if (wr_out) outval_q <= bus_wdata[PINS-1:0];
      if (wr_dir) dir_q    <= bus_wdata[PINS-1:0];
      if (wr_tlo) cfg_lo_q <= bus_wdata[CFG_W-1:0];
      if (wr_thi) cfg_hi_q <= bus_wdata[CFG_W-1:0];
      if (wr_msk) mask_q   <= bus_wdata[PINS-1:0];
      // A trigger in the same cycle as a clear wins.
      stat_q <= (stat_q & ~clr_vec) | hit_vec;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(OFS_OUTVAL))      bus_rdata = DW'(outval_q);
    else if (bus_addr == AW'(OFS_DIR))    bus_rdata = DW'(dir_q);
    else if (bus_addr == AW'(OFS_LEVEL))  bus_rdata = DW'(level_q);
    else if (bus_addr == AW'(OFS_TRIGLO)) bus_rdata = DW'(cfg_lo_q);
    else if (bus_addr == AW'(OFS_TRIGHI)) bus_rdata = DW'(cfg_hi_q);
    else if (bus_addr == AW'(OFS_MASK))   bus_rdata = DW'(mask_q);
    else if (bus_addr == AW'(OFS_STAT))   bus_rdata = DW'(stat_q);
  end
endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
module gpio_irq_port #(
  parameter int unsigned PINS   = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned AW     = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_en,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe,
  output logic            irq_lo,
  output logic            irq_hi
);
  localparam int unsigned HALF  = PINS / 2;
  localparam int unsigned CFG_W = 2 * HALF;

  logic [PINS-1:0]  level_q, level_prev;
  logic [PINS-1:0]  hit_vec, clr_vec;
  logic [PINS-1:0]  outval_q, dir_q, mask_q, stat_q;
  logic [CFG_W-1:0] cfg_lo_q, cfg_hi_q;
  logic [PINS-1:0]  pend_vec;

  gpio_sync #(.W(PINS), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(level_q), .q_prev(level_prev)
  );

  gpio_trig #(.PINS(PINS)) u_trig (
    .cfg_lo(cfg_lo_q), .cfg_hi(cfg_hi_q),
    .cur(level_q), .prv(level_prev), .hit(hit_vec)
  );

  gpio_regs #(.PINS(PINS), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .level_q(level_q), .hit_vec(hit_vec), .bus_rdata(bus_rdata),
    .outval_q(outval_q), .dir_q(dir_q), .cfg_lo_q(cfg_lo_q), .cfg_hi_q(cfg_hi_q),
    .mask_q(mask_q), .stat_q(stat_q), .clr_vec(clr_vec)
  );

  assign pend_vec = stat_q & mask_q;
  assign irq_lo   = |pend_vec[HALF-1:0];
  assign irq_hi   = |pend_vec[PINS-1:HALF];
  assign pin_oe   = dir_q;
  assign pin_out  = outval_q & dir_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
`timescale 1ns/1ps
module gpio_irq_port_chk #(
  parameter int unsigned PINS = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_lo,
  input logic            irq_hi,
  input logic [PINS-1:0] pin_out,
  input logic [PINS-1:0] pin_oe,
  input logic [PINS-1:0] mask_q,
  input logic [PINS-1:0] stat_q,
  input logic [PINS-1:0] hit_vec,
  input logic [PINS-1:0] clr_vec
);
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_q & ~clr_vec) & ~stat_q) == '0)); // R5

  AST_SET_BY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(hit_vec)) == '0)); // R4

  AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> (!irq_lo && !irq_hi)); // R6

  AST_IRQ_ANY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lo || irq_hi) == ($countones(stat_q & mask_q) != 0)); // R7

  AST_NO_DRIVE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & ~pin_oe) == '0)); // R2
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_lo(irq_lo), .irq_hi(irq_hi),
  .pin_out(pin_out), .pin_oe(pin_oe), .mask_q(mask_q), .stat_q(stat_q),
  .hit_vec(hit_vec), .clr_vec(clr_vec)
);

// File: tb/test_gpio_irq_port.sv
`timescale 1ns/1ps
module test_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pin_in = '0, pin_out, pin_oe;
  logic        irq_lo, irq_hi;

  int nchk = 0, nfail = 0;
  string       tag_q[$];
  logic [31:0] exp_q[$];

  localparam logic [4:0] A_OUT = 5'h00, A_DIR = 5'h04, A_LVL = 5'h08,
                         A_TLO = 5'h0C, A_THI = 5'h10, A_MSK = 5'h14, A_STA = 5'h18;

  always #2.5 clk = ~clk;

  gpio_irq_port i_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  // Driver: queue the expected read value, then issue the read.
  task automatic do_read(string tag, logic [4:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    tag_q.push_back(tag);
    exp_q.push_back(exp);
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare each read against the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (bus_en && !bus_we) begin
        if (exp_q.size() == 0) begin
          nchk++; nfail++;
          $display("FAIL scoreboard empty actual=%h expected=none", bus_rdata);
        end else begin
          chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    // R1: reset state
    idle(2);
    chk("R1 pin_oe in reset", pin_oe, 32'h0);
    chk("R1 pin_out in reset", pin_out, 32'h0);
    chk("R1 irq in reset", {30'h0, irq_hi, irq_lo}, 32'h0);
    do_read("R1 status in reset", A_STA, 32'h0);
    do_read("R1 mask in reset", A_MSK, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    do_read("R1 outval", A_OUT, 32'h0);
    do_read("R1 dir", A_DIR, 32'h0);
    do_read("R1 trig lo", A_TLO, 32'h0);
    do_read("R1 trig hi", A_THI, 32'h0);

    // All pins to rising edge, then clear everything
    do_write(A_TLO, 32'hAAAA_AAAA);
    do_write(A_THI, 32'hAAAA_AAAA);
    idle(3);
    do_write(A_STA, 32'hFFFF_FFFF);
    do_read("R5 cleared", A_STA, 32'h0);

    // R2: direction and output value
    do_write(A_DIR, 32'h0000_FFFF);
    do_write(A_OUT, 32'hA5A5_A5A5);
    chk("R2 pin_oe", pin_oe, 32'h0000_FFFF);
    chk("R2 pin_out", pin_out, 32'h0000_A5A5);
    do_read("R2 dir readback", A_DIR, 32'h0000_FFFF);
    do_read("R2 outval readback", A_OUT, 32'hA5A5_A5A5);

    // R3: pad level latency; R10: rising edges
    pin_in = 32'h1234_5678;
    do_read("R3 level one cycle after", A_LVL, 32'h0);
    do_read("R3 level after sync", A_LVL, 32'h1234_5678);
    do_read("R10 rising sets status", A_STA, 32'h1234_5678);
    chk("R6 mask zero no irq", {30'h0, irq_hi, irq_lo}, 32'h0);

    // R6 / R7: mask gating per half
    do_write(A_MSK, 32'h0000_0010);
    chk("R7 low half only", {30'h0, irq_hi, irq_lo}, 32'h1);
    do_write(A_MSK, 32'h0004_0000);
    chk("R7 high half only", {30'h0, irq_hi, irq_lo}, 32'h2);

    // R5: write-one-to-clear
    do_write(A_STA, 32'h0000_0010);
    do_read("R5 one clears", A_STA, 32'h1234_5668);
    do_write(A_STA, 32'h0000_0000);
    do_read("R5 zero keeps", A_STA, 32'h1234_5668);
    do_write(A_STA, 32'hFFFF_FFFF);
    idle(2);
    do_read("R10 steady edge no reset", A_STA, 32'h0);

    // R4: pin 20 falling via upper register field bits 9:8
    do_write(A_THI, 32'hAAAA_ABAA);
    do_read("R4 trig hi readback", A_THI, 32'hAAAA_ABAA);
    pin_in = 32'h1224_5678;
    idle(4);
    do_read("R4 R10 falling pin20", A_STA, 32'h0010_0000);
    chk("R6 unmasked pin no irq", {30'h0, irq_hi, irq_lo}, 32'h0);
    do_write(A_MSK, 32'h0010_0000);
    chk("R7 pin20 on high line", {30'h0, irq_hi, irq_lo}, 32'h2);

    // R8 / R9: level triggers, pin0 low, pin1 high
    do_write(A_MSK, 32'h0);
    do_write(A_TLO, 32'hAAAA_AAA4);
    idle(2);
    do_write(A_STA, 32'hFFFF_FFFF);
    do_read("R8 low level defeats clear", A_STA, 32'h0000_0001);
    pin_in = 32'h1224_567B;
    idle(4);
    do_write(A_STA, 32'h0000_0001);
    do_read("R9 high level sets pin1", A_STA, 32'h0000_0002);
    do_write(A_STA, 32'h0000_0002);
    do_read("R9 high level defeats clear", A_STA, 32'h0000_0002);
    do_write(A_MSK, 32'h0000_0002);
    chk("R6 masked level irq", {30'h0, irq_hi, irq_lo}, 32'h1);
    do_read("R3 level with outputs", A_LVL, 32'h1224_567B);

    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule